// File: doc/BRIEF.md
# Write-Pointer Update Coalescer

An interrupt ring producer writes entries into memory and has to tell the consumer how far it has written. Publishing the write pointer after every entry costs bus traffic, and publishing it too rarely leaves entries unseen. This block sits beside the producer and decides when a publish is due. It counts the entries written since the last publish. It fires a publish when that count reaches a programmable power-of-two threshold. It also fires when a flush timer runs out while entries are still waiting.

Both limits are programmed as exponents. The threshold code `n` gives 2^n entries. The timeout code `m` gives 2^m × 1024 clock cycles. The timer runs only while at least one entry is unpublished and only while the flush enable is set. Each publish is a registered one-cycle pulse that carries the write pointer present in the cycle the decision was taken.

Top module: `wptr_publish_coalescer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pub_valid` is 0 and `pub_ptr` is 0. The reset configuration is threshold code 0, timeout code 8 and flush disabled.
- R2: Each cycle with `wr_stb` high adds one to the pending count. When the pending count, including the current strobe, reaches 2^(threshold code), `pub_valid` is high in the following cycle.
- R3: On a publish, `pub_ptr` takes the `wr_ptr` value of the deciding cycle. It holds that value until the next publish, and `pub_valid` is low in every cycle that follows a cycle with no publish decision.
- R4: With flush enabled and the threshold not reached, if the first pending entry is sampled at clock edge E0, the publish is decided at edge E0 + 2^(timeout code) × 1024. Later entries inside the window do not restart it.
- R5: With flush disabled, pending entries never cause a publish by time, however long they wait.
- R6: A publish clears the pending count and the flush timer. An entry strobed in the deciding cycle is part of that publish and is not carried over.
- R7: When the threshold is reached on the same edge that the timer expires, exactly one single-cycle publish pulse results and nothing is left pending.
- R8: A threshold code above 15 acts as 15 (32768 entries). A timeout code above 20 acts as 20.
- R9: The codes and the enable are registered. A change driven before edge K is first used for a decision at edge K+1.
- R10: Lowering the threshold to or below the count already pending causes a publish without any new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One entry written this cycle |
| wr_ptr | input | PTR_W | Current producer write pointer |
| thr_code | input | THR_CODE_W | Threshold exponent (saturates at THR_MAX) |
| tmo_code | input | TMO_CODE_W | Timeout exponent (saturates at TMO_MAX) |
| tmo_en | input | 1 | Enables the timed flush |
| pub_valid | output | 1 | Publish pulse, registered |
| pub_ptr | output | PTR_W | Pointer being published, held between publishes |

## Verification
The threshold compare and the flush timer expiry can fall on the same clock edge. The bench provokes this with a two-entry threshold and a 1024-cycle window. It places the second entry exactly on the edge where the window closes. It then expects one pulse carrying that second entry's pointer, and no further pulse over three more windows, which shows that nothing remained pending. Random phases with dense, sparse and very sparse strobes, toggled enables and changing thresholds are compared cycle by cycle against an independent reference model. That model uses a single cycle-age counter in place of the hardware's prescaled timer.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  // Which condition decided a publish in the current cycle.
  typedef enum logic [1:0] {
    FIRE_NONE  = 2'd0,
    FIRE_COUNT = 2'd1,
    FIRE_TIMER = 2'd2,
    FIRE_BOTH  = 2'd3
  } fire_cause_e;

endpackage

// File: rtl/wpc_cfg_stage.sv
// Registers the programmable codes, saturates them and decodes them into
// ready-to-compare limits so the publish decision path sees flops only.
module wpc_cfg_stage #(
  parameter int THR_CODE_W = 5,
  parameter int TMO_CODE_W = 5,
  parameter int THR_MAX    = 15,
  parameter int TMO_MAX    = 20,
  parameter int THR_RST    = 0,
  parameter int TMO_RST    = 8,
  localparam int CNT_W     = THR_MAX + 1,
  localparam int TICK_W    = TMO_MAX + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [THR_CODE_W-1:0] thr_code,
  input  logic [TMO_CODE_W-1:0] tmo_code,
  input  logic                  tmo_en,
  output logic [CNT_W-1:0]      thr_lim,
  output logic [TICK_W-1:0]     tick_last,
  output logic                  en_q
);

  localparam logic [THR_CODE_W-1:0] THR_CAP = THR_CODE_W'(THR_MAX);
  localparam logic [TMO_CODE_W-1:0] TMO_CAP = TMO_CODE_W'(TMO_MAX);
  localparam logic [THR_CODE_W-1:0] THR_DEF = THR_CODE_W'(THR_RST);
  localparam logic [TMO_CODE_W-1:0] TMO_DEF = TMO_CODE_W'(TMO_RST);

  logic [THR_CODE_W-1:0] thr_sat;
  logic [TMO_CODE_W-1:0] tmo_sat;
  logic [CNT_W-1:0]      thr_lim_d;
  logic [TICK_W-1:0]     tick_last_d;

  always_comb begin
    thr_sat     = (thr_code > THR_CAP) ? THR_CAP : thr_code;
    tmo_sat     = (tmo_code > TMO_CAP) ? TMO_CAP : tmo_code;
    thr_lim_d   = CNT_W'(1) << thr_sat;
    tick_last_d = (TICK_W'(1) << tmo_sat) - TICK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_lim   <= CNT_W'(1) << THR_DEF;
      tick_last <= (TICK_W'(1) << TMO_DEF) - TICK_W'(1);
      en_q      <= 1'b0;
    end else begin
      thr_lim   <= thr_lim_d;
      tick_last <= tick_last_d;
      en_q      <= tmo_en;
    end
  end

endmodule

// File: rtl/wpc_pend_counter.sv
// Counts entries written since the last publish and flags the threshold.
module wpc_pend_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             clear,
  input  logic [CNT_W-1:0] thr_lim,
  output logic             thr_hit,
  output logic             pend_nz
);

  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] cnt_next;

  // The current strobe is counted before the compare, so it joins this publish.
  assign cnt_next = pend_q + CNT_W'(strobe);
  assign thr_hit  = (cnt_next >= thr_lim);
  assign pend_nz  = |pend_q;

  always_ff @(posedge clk) begin
    if (rst || clear) pend_q <= '0;
    else              pend_q <= cnt_next;
  end

endmodule

// File: rtl/wpc_flush_timer.sv
// Flush window timer: a free-running prescaler of 2^PRE_LOG2 cycles feeding
// a tick counter compared against the decoded exponent limit.
module wpc_flush_timer #(
  parameter int PRE_LOG2 = 10,
  parameter int TICK_W   = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  input  logic [TICK_W-1:0] tick_last,
  output logic              expire,
  output logic              idle
);

  logic              presc_wrap;
  logic              presc_zero;
  logic [TICK_W-1:0] ticks_q;

  generate
    if (PRE_LOG2 > 0) begin : g_pre
      logic [PRE_LOG2-1:0] presc_q;
      always_ff @(posedge clk) begin
        if (rst || clear || !run) presc_q <= '0;
        else                      presc_q <= presc_q + PRE_LOG2'(1);
      end
      assign presc_wrap = &presc_q;
      assign presc_zero = (presc_q == '0);
    end else begin : g_nopre
      assign presc_wrap = 1'b1;
      assign presc_zero = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear || !run) ticks_q <= '0;
    else if (presc_wrap)      ticks_q <= ticks_q + TICK_W'(1);
  end

  assign expire = run && presc_wrap && (ticks_q >= tick_last);
  assign idle   = presc_zero && (ticks_q == '0);

endmodule

// File: rtl/wptr_publish_coalescer.sv
// Decides when the producer's write pointer must be published: on reaching
// an entry-count threshold or when a flush window ends with entries pending.
module wptr_publish_coalescer #(
  parameter int PTR_W      = 18,
  parameter int THR_CODE_W = 5,
  parameter int TMO_CODE_W = 5,
  parameter int THR_MAX    = 15,
  parameter int TMO_MAX    = 20,
  parameter int PRE_LOG2   = 10,
  parameter int THR_RST    = 0,
  parameter int TMO_RST    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic [THR_CODE_W-1:0] thr_code,
  input  logic [TMO_CODE_W-1:0] tmo_code,
  input  logic                  tmo_en,
  output logic                  pub_valid,
  output logic [PTR_W-1:0]      pub_ptr
);

  import wpc_pkg::*;

  localparam int CNT_W  = THR_MAX + 1;
  localparam int TICK_W = TMO_MAX + 1;

  logic [CNT_W-1:0]  thr_lim;
  logic [TICK_W-1:0] tick_last;
  logic              en_q;
  logic              thr_hit;
  logic              pend_nz;
  logic              tmr_expire;
  logic              tmr_idle;
  logic              fire;
  fire_cause_e       cause;

  wpc_cfg_stage #(
    .THR_CODE_W (THR_CODE_W),
    .TMO_CODE_W (TMO_CODE_W),
    .THR_MAX    (THR_MAX),
    .TMO_MAX    (TMO_MAX),
    .THR_RST    (THR_RST),
    .TMO_RST    (TMO_RST)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .thr_code  (thr_code),
    .tmo_code  (tmo_code),
    .tmo_en    (tmo_en),
    .thr_lim   (thr_lim),
    .tick_last (tick_last),
    .en_q      (en_q)
  );

  wpc_pend_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .strobe  (wr_stb),
    .clear   (fire),
    .thr_lim (thr_lim),
    .thr_hit (thr_hit),
    .pend_nz (pend_nz)
  );

  wpc_flush_timer #(
    .PRE_LOG2 (PRE_LOG2),
    .TICK_W   (TICK_W)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .run       (pend_nz && en_q),
    .clear     (fire),
    .tick_last (tick_last),
    .expire    (tmr_expire),
    .idle      (tmr_idle)
  );

  // Both causes merge into one decision, so a coincidence gives one pulse.
  assign cause = fire_cause_e'({tmr_expire, thr_hit});
  assign fire  = (cause != FIRE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pub_valid <= 1'b0;
      pub_ptr   <= '0;
    end else begin
      pub_valid <= fire;
      if (fire) pub_ptr <= wr_ptr;
    end
  end

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int PTR_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             pub_valid,
  input logic [PTR_W-1:0] pub_ptr,
  input logic             thr_hit,
  input logic             tmr_expire,
  input logic             pend_nz,
  input logic             tmr_idle,
  input logic             en_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pub_valid);

  // R2
  count_fire_chk: assert property (@(posedge clk) disable iff (rst)
    thr_hit |=> pub_valid);

  // R3
  ptr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_hit || tmr_expire) |=> (pub_ptr == $past(wr_ptr)));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(thr_hit || tmr_expire) |=> (!pub_valid && $stable(pub_ptr)));

  // R4
  timer_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_nz |-> tmr_idle);

  // R5
  flush_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !tmr_expire);

  // R6
  clear_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_hit || tmr_expire) |=> (!pend_nz && tmr_idle));

  // R7
  coincide_once_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_hit && tmr_expire) |=> (pub_valid && !pend_nz));

endmodule

bind wptr_publish_coalescer wpc_checker #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_ptr     (wr_ptr),
  .pub_valid  (pub_valid),
  .pub_ptr    (pub_ptr),
  .thr_hit    (thr_hit),
  .tmr_expire (tmr_expire),
  .pend_nz    (pend_nz),
  .tmr_idle   (tmr_idle),
  .en_q       (en_q)
);

// File: tb/sim_wptr_publish_coalescer.sv
module sim_wptr_publish_coalescer;

  localparam int PTR_W    = 18;
  localparam int CW       = 5;
  localparam int THR_RST  = 0;
  localparam int TMO_RST  = 8;
  localparam int WD_LIMIT = 195000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_stb = 1'b0;
  logic [PTR_W-1:0] wr_ptr = '0;
  logic [CW-1:0]    thr_code = '0;
  logic [CW-1:0]    tmo_code = '0;
  logic             tmo_en = 1'b0;
  logic             pub_valid;
  logic [PTR_W-1:0] pub_ptr;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  bit cmp_on   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wptr_publish_coalescer u0 (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_ptr    (wr_ptr),
    .thr_code  (thr_code),
    .tmo_code  (tmo_code),
    .tmo_en    (tmo_en),
    .pub_valid (pub_valid),
    .pub_ptr   (pub_ptr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp_v);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  function automatic longint thr_limit(input int code);
    int c = (code > 15) ? 15 : code;
    return longint'(1) << c;
  endfunction

  function automatic longint tmo_cycles(input int code);
    int c = (code > 20) ? 20 : code;
    return (longint'(1) << c) * 1024;
  endfunction

  // Reference model: pending count plus one cycle-age counter.
  longint m_pend = 0;
  longint m_age  = 0;
  int     m_thr  = THR_RST;
  int     m_tmo  = TMO_RST;
  bit     m_en   = 1'b0;
  bit     e_valid = 1'b0;
  logic [PTR_W-1:0] e_ptr = '0;
  string  e_tag = "R1";

  always @(posedge clk) begin
    longint n;
    bit hit, tex;
    if (rst) begin
      m_pend = 0; m_age = 0; m_thr = THR_RST; m_tmo = TMO_RST; m_en = 1'b0;
      e_valid = 1'b0; e_ptr = '0; e_tag = "R1";
    end else begin
      n   = m_pend + (wr_stb ? 1 : 0);
      hit = (n >= thr_limit(m_thr));
      tex = m_en && (m_pend != 0) && (m_age >= tmo_cycles(m_tmo) - 1);
      e_valid = hit || tex;
      e_tag = (hit && tex) ? "R7" : (hit ? "R2" : (tex ? "R4" : (m_en ? "R4" : "R5")));
      if (e_valid) begin
        e_ptr = wr_ptr; m_pend = 0; m_age = 0;
      end else begin
        if (m_en && m_pend != 0) m_age = m_age + 1;
        else                     m_age = 0;
        m_pend = n;
      end
      m_thr = int'(thr_code); m_tmo = int'(tmo_code); m_en = tmo_en;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(pub_valid === e_valid, e_tag, longint'(pub_valid), longint'(e_valid));
      check(pub_ptr === e_ptr, "R3", longint'(pub_ptr), longint'(e_ptr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_checks++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic set_cfg(input int t, input int m, input bit en);
    @(negedge clk);
    thr_code = CW'(t); tmo_code = CW'(m); tmo_en = en; wr_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Called in the negedge where a strobe has just been driven.
  task automatic expect_pub_after(input int n, input string tag, input logic [PTR_W-1:0] p);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      if (k < n) check(pub_valid == 1'b0, tag, longint'(pub_valid), 0);
      else begin
        check(pub_valid == 1'b1, tag, longint'(pub_valid), 1);
        check(pub_ptr == p, tag, longint'(pub_ptr), longint'(p));
      end
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      check(pub_valid == 1'b0, tag, longint'(pub_valid), 0);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic random_phase(input int cycles, input int den, input int tcode);
    thr_code = CW'($urandom % 6); tmo_code = CW'(tcode); tmo_en = 1'b1;
    do_reset();
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      wr_stb = (($urandom % den) == 0);
      wr_ptr = PTR_W'($urandom);
      if (($urandom % 2000) == 0) thr_code = CW'($urandom % 22);
      if (($urandom % 3000) == 0) tmo_en = ~tmo_en;
    end
  endtask

  initial begin
    logic [PTR_W-1:0] base;
    void'($urandom(32'd5150));
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check(pub_valid == 1'b0, "R1", longint'(pub_valid), 0);
    check(pub_ptr == '0, "R1", longint'(pub_ptr), 0);

    // R2/R3: threshold 1 publishes every entry; pointer then held
    set_cfg(0, 8, 1'b0);
    wr_stb = 1'b1; wr_ptr = 18'h00111;
    expect_pub_after(1, "R2", 18'h00111);
    @(negedge clk);
    check(pub_valid == 1'b0, "R3", longint'(pub_valid), 0);
    check(pub_ptr == 18'h00111, "R3", longint'(pub_ptr), 18'h00111);

    // R2: threshold 4
    set_cfg(2, 8, 1'b0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check(pub_valid == 1'b0, "R2", longint'(pub_valid), 0);
      wr_stb = 1'b1; wr_ptr = PTR_W'(i);
    end
    @(negedge clk);
    check(pub_valid == 1'b0, "R2", longint'(pub_valid), 0);
    wr_stb = 1'b1; wr_ptr = 18'd4;
    expect_pub_after(1, "R2", 18'd4);

    // R6: back-to-back strobes, publishes after the 4th and 8th
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check(pub_valid == (i == 5), "R6", longint'(pub_valid), longint'(i == 5));
      wr_stb = 1'b1; wr_ptr = PTR_W'(i + 16);
    end
    expect_pub_after(1, "R6", 18'd24);

    // R5: flush disabled, 1024-cycle window would have expired
    set_cfg(3, 0, 1'b0);
    wr_stb = 1'b1; wr_ptr = 18'h00020;
    quiet(5000, "R5");

    // R9 then R10: lower threshold below pending count
    thr_code = CW'(0); wr_ptr = 18'h0002A;
    @(negedge clk);
    check(pub_valid == 1'b0, "R9", longint'(pub_valid), 0);
    @(negedge clk);
    check(pub_valid == 1'b1, "R10", longint'(pub_valid), 1);
    check(pub_ptr == 18'h0002A, "R10", longint'(pub_ptr), 18'h0002A);

    // R4: timed flush after exactly 1024 cycles
    set_cfg(4, 0, 1'b1);
    wr_stb = 1'b1; wr_ptr = 18'h03001;
    expect_pub_after(1025, "R4", 18'h03001);

    // R4: 2048-cycle window, later entries do not restart it
    set_cfg(4, 1, 1'b1);
    base = 18'h04000;
    wr_stb = 1'b1; wr_ptr = base;
    for (int k = 1; k <= 2049; k++) begin
      @(negedge clk);
      wr_stb = (k == 500 || k == 900 || k == 1500);
      if (wr_stb) wr_ptr = base + PTR_W'(k);
      check(pub_valid == (k == 2049), "R4", longint'(pub_valid), longint'(k == 2049));
    end
    check(pub_ptr == base + 18'd1500, "R4", longint'(pub_ptr), longint'(base + 18'd1500));

    // R7: threshold 2 reached on the edge the window expires
    set_cfg(1, 0, 1'b1);
    base = 18'h05000;
    wr_stb = 1'b1; wr_ptr = base;
    for (int k = 1; k <= 1025; k++) begin
      @(negedge clk);
      wr_stb = (k == 1024);
      if (k == 1024) wr_ptr = base + 18'd1;
      check(pub_valid == (k == 1025), "R7", longint'(pub_valid), longint'(k == 1025));
    end
    check(pub_ptr == base + 18'd1, "R7", longint'(pub_ptr), longint'(base + 18'd1));
    quiet(3100, "R7");

    // R6: entry on the expiry edge joins the timed publish
    set_cfg(4, 0, 1'b1);
    base = 18'h06000;
    wr_stb = 1'b1; wr_ptr = base;
    for (int k = 1; k <= 1025; k++) begin
      @(negedge clk);
      wr_stb = (k == 1024);
      if (k == 1024) wr_ptr = base + 18'd7;
      check(pub_valid == (k == 1025), "R6", longint'(pub_valid), longint'(k == 1025));
    end
    check(pub_ptr == base + 18'd7, "R6", longint'(pub_ptr), longint'(base + 18'd7));
    quiet(3100, "R6");

    // R8: threshold code 31 acts as 15
    set_cfg(31, 0, 1'b0);
    for (int i = 1; i <= 32768; i++) begin
      @(negedge clk);
      if (pub_valid != 1'b0) check(1'b0, "R8", longint'(pub_valid), 0);
      wr_stb = 1'b1; wr_ptr = PTR_W'(i);
    end
    check(1'b1, "R8", 0, 0);
    expect_pub_after(1, "R8", 18'd32768);

    // R8: timeout code 31 acts as 20, so no flush soon
    set_cfg(15, 31, 1'b1);
    wr_stb = 1'b1; wr_ptr = 18'h07000;
    quiet(4096, "R8");
    thr_code = CW'(0);
    @(negedge clk);
    @(negedge clk);
    check(pub_valid == 1'b1, "R10", longint'(pub_valid), 1);

    // Random phases against the model
    random_phase(15000, 3, 0);
    random_phase(15000, 200, 1);
    random_phase(15000, 700, 0);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule